// File: doc/BRIEF.md
# Serial TDM Highway to Timeslot Byte Converter

This block takes a serial time-division-multiplexed bit stream from a system highway and delivers it as parallel bytes, one per timeslot. All inputs are captured on the falling edge of the working clock. A frame sync pulse sets the frame alignment. A two-level offset sets how far after that pulse timeslot 0 begins: a count of whole timeslots, plus a count of single clocks, plus an optional extra clock. A mode input sets how many working clocks make up one bit.

Once aligned, the block runs freely from frame to frame. Sync pulses may recur at any whole multiple of the frame length. A sync that lands on the expected frame grid changes nothing. A sync that lands anywhere else makes the block realign at once and report the event. Each completed timeslot is presented as a byte with its index and a one-clock strobe. A separate flag marks the first clock of every frame.

Top module: `tdm_hwy_deser`

## Requirements
- R1: After reset every output is low, and the byte strobe stays low until the first sync pulse has been sampled.
- R2: Within each bit period only the last working clock samples the data input. Values present on the other clocks of the period do not reach the byte output.
- R3: The mode code sets the bit period and frame size: 0 gives 1 clock per bit and 32 slots; 1 gives 2 clocks per bit and 64 slots; 2 and 3 both give 4 clocks per bit and 32 slots. A slot is 8 bits.
- R4: Let D = slot offset × 8 × clocks-per-bit + clock offset + extra bit. The first clock of timeslot 0 is the (D+1)-th falling edge after the edge that sampled the aligning sync.
- R5: Bits are assembled MSB first. The byte strobe rises for exactly one clock after the final sampling clock of each slot, together with the byte and its slot index.
- R6: The slot index wraps to 0 after the last slot, and frames continue with no further sync. The frame-start flag pulses for one clock after the first clock of slot 0 of every frame.
- R7: A sync sampled a whole number of frames after the aligning sync has no effect: there is no resync pulse, and the byte stream continues without a gap.
- R8: A sync sampled off the frame grid while aligned causes a one-clock resync pulse and starts a new offset count from that edge. No byte strobe or frame-start flag is issued for that edge.
- R9: Mode and offset inputs are captured only on an edge that (re)aligns. Changes to them at other times have no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Working clock; all inputs are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync pulse |
| sdata_i | input | 1 | Serial highway data |
| mode_i | input | 2 | Clocks-per-bit / frame size code |
| ts_ofs_i | input | 6 | Offset of slot 0 in whole timeslots |
| clk_ofs_i | input | 3 | Offset of slot 0 in working clocks |
| edge_adj_i | input | 1 | Adds one further clock of offset |
| byte_o | output | 8 | Assembled timeslot byte |
| slot_o | output | 6 | Index of the slot in byte_o |
| byte_vld_o | output | 1 | One-clock strobe for byte_o and slot_o |
| frame_start_o | output | 1 | Pulse marking the first clock of slot 0 |
| resync_o | output | 1 | Pulse marking an off-grid sync that forced realignment |

## Verification
The assertions check on every cycle that the strobe never lasts two clocks, that it stays silent until alignment, that slot indices stay inside the frame of the captured mode, and that a resync edge issues neither a strobe nor a frame flag. Only the bench scenarios can show that byte values and slot indices are correct. The same holds for the exact edge that R4's offset formula places, for MSB-first order while non-sampling clocks carry noise, and for a stream that continues across on-grid syncs while the configuration inputs change at random.

// File: rtl/tdm_deser_pkg.sv
package tdm_deser_pkg;
  localparam int MODE_W     = 2;
  localparam int TSO_W      = 6;
  localparam int CSO_W      = 3;
  localparam int BYTE_W     = 8;
  localparam int BASE_SLOTS = 32;
  localparam int MAX_CPB    = 4;
  localparam int BIT_W      = $clog2(BYTE_W);
  localparam int PH_W       = $clog2(MAX_CPB);
  localparam int SLOT_W     = $clog2(2 * BASE_SLOTS);
  localparam int FPOS_W     = $clog2(BASE_SLOTS * BYTE_W * MAX_CPB);
  localparam int DLY_W      = $clog2((2**TSO_W - 1) * BYTE_W * MAX_CPB + 2**CSO_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} align_st_t;

  function automatic int cpb_of(input logic [MODE_W-1:0] m);
    case (m)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int slots_of(input logic [MODE_W-1:0] m);
    return (m == 2'd1) ? 2 * BASE_SLOTS : BASE_SLOTS;
  endfunction

  function automatic logic [PH_W-1:0] ph_last(input logic [MODE_W-1:0] m);
    return PH_W'(cpb_of(m) - 1);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_last(input logic [MODE_W-1:0] m);
    return SLOT_W'(slots_of(m) - 1);
  endfunction

  function automatic logic [FPOS_W-1:0] frame_last(input logic [MODE_W-1:0] m);
    return FPOS_W'(slots_of(m) * BYTE_W * cpb_of(m) - 1);
  endfunction

  function automatic logic [DLY_W-1:0] delay_of(input logic [MODE_W-1:0] m,
                                                input logic [TSO_W-1:0] tso,
                                                input logic [CSO_W-1:0] cso,
                                                input logic adj);
    return DLY_W'(int'(tso) * BYTE_W * cpb_of(m) + int'(cso) + int'(adj));
  endfunction
endpackage

// File: rtl/tdm_sync_align.sv
module tdm_sync_align
  import tdm_deser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TSO_W-1:0]  tso_i,
  input  logic [CSO_W-1:0]  cso_i,
  input  logic              adj_i,
  output logic [MODE_W-1:0] mode_q,
  output logic              active_o,
  output logic              restart_o,
  output logic              locked_o,
  output logic              resync_o
);
  align_st_t         st;
  logic [DLY_W-1:0]  dly;
  logic [FPOS_W-1:0] fpos;
  logic              on_grid;
  logic              load;

  // The frame grid counts from the last aligning sync.
  assign on_grid   = (fpos == frame_last(mode_q));
  assign load      = sync_i & ((st == ST_IDLE) | !on_grid);
  assign active_o  = !load & ((st == ST_RUN) | ((st == ST_WAIT) & (dly == '0)));
  assign restart_o = load;
  assign locked_o  = (st != ST_IDLE);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      dly      <= '0;
      fpos     <= '0;
      mode_q   <= '0;
      resync_o <= 1'b0;
    end else begin
      resync_o <= sync_i & (st != ST_IDLE) & !on_grid;
      if (load) begin
        mode_q <= mode_i;
        dly    <= delay_of(mode_i, tso_i, cso_i, adj_i);
        st     <= ST_WAIT;
        fpos   <= '0;
      end else begin
        if (st != ST_IDLE) fpos <= on_grid ? '0 : fpos + 1'b1;
        if (st == ST_WAIT) begin
          if (dly == '0) st <= ST_RUN;
          else           dly <= dly - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer
  import tdm_deser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              restart_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              sample_o,
  output logic              byte_end_o,
  output logic              first_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [PH_W-1:0]   ph;
  logic [BIT_W-1:0]  bt;
  logic              ph_wrap;
  logic              bt_wrap;
  logic              sl_wrap;

  assign ph_wrap    = (ph == ph_last(mode_i));
  assign bt_wrap    = (bt == BIT_W'(BYTE_W - 1));
  assign sl_wrap    = (slot_o == slot_last(mode_i));
  assign sample_o   = active_i & ph_wrap;
  assign byte_end_o = sample_o & bt_wrap;
  assign first_o    = active_i & (ph == '0) & (bt == '0) & (slot_o == '0);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      bt     <= '0;
      slot_o <= '0;
    end else if (restart_i) begin
      ph     <= '0;
      bt     <= '0;
      slot_o <= '0;
    end else if (active_i) begin
      ph <= ph_wrap ? '0 : ph + 1'b1;
      if (ph_wrap) begin
        bt <= bt + 1'b1;
        if (bt_wrap) slot_o <= sl_wrap ? '0 : slot_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_byte_asm.sv
module tdm_byte_asm
  import tdm_deser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata_i,
  input  logic              sample_i,
  input  logic              byte_end_i,
  input  logic              first_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              vld_o,
  output logic              fstart_o
);
  logic [BYTE_W-2:0] sh;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      byte_o   <= '0;
      slot_o   <= '0;
      vld_o    <= 1'b0;
      fstart_o <= 1'b0;
    end else begin
      fstart_o <= first_i;
      vld_o    <= byte_end_i;
      if (sample_i) sh <= {sh[BYTE_W-3:0], sdata_i};
      if (byte_end_i) begin
        byte_o <= {sh, sdata_i};
        slot_o <= slot_i;
      end
    end
  end
endmodule

// File: rtl/tdm_hwy_deser.sv
module tdm_hwy_deser
  import tdm_deser_pkg::*;
(
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic              sdata_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TSO_W-1:0]  ts_ofs_i,
  input  logic [CSO_W-1:0]  clk_ofs_i,
  input  logic              edge_adj_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              byte_vld_o,
  output logic              frame_start_o,
  output logic              resync_o
);
  logic [MODE_W-1:0] mode_w;
  logic              active_w;
  logic              restart_w;
  logic              locked_w;
  logic              sample_w;
  logic              byte_end_w;
  logic              first_w;
  logic [SLOT_W-1:0] tslot_w;

  tdm_sync_align i_align (
    .clk       (sclk),
    .rst_n     (rst_n),
    .sync_i    (fsync_i),
    .mode_i    (mode_i),
    .tso_i     (ts_ofs_i),
    .cso_i     (clk_ofs_i),
    .adj_i     (edge_adj_i),
    .mode_q    (mode_w),
    .active_o  (active_w),
    .restart_o (restart_w),
    .locked_o  (locked_w),
    .resync_o  (resync_o)
  );

  tdm_bit_timer i_timer (
    .clk        (sclk),
    .rst_n      (rst_n),
    .active_i   (active_w),
    .restart_i  (restart_w),
    .mode_i     (mode_w),
    .sample_o   (sample_w),
    .byte_end_o (byte_end_w),
    .first_o    (first_w),
    .slot_o     (tslot_w)
  );

  tdm_byte_asm i_asm (
    .clk        (sclk),
    .rst_n      (rst_n),
    .sdata_i    (sdata_i),
    .sample_i   (sample_w),
    .byte_end_i (byte_end_w),
    .first_i    (first_w),
    .slot_i     (tslot_w),
    .byte_o     (byte_o),
    .slot_o     (slot_o),
    .vld_o      (byte_vld_o),
    .fstart_o   (frame_start_o)
  );
endmodule

// File: rtl/tdm_hwy_deser_chk.sv
module tdm_hwy_deser_chk
  import tdm_deser_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld_o,
  input logic              frame_start_o,
  input logic              resync_o,
  input logic [SLOT_W-1:0] slot_o,
  input logic              locked,
  input logic [MODE_W-1:0] mode_q
);
  AST_STROBE_SINGLE: assert property (@(negedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);                                 // R5
  AST_NO_STROBE_UNALIGNED: assert property (@(negedge clk) disable iff (!rst_n)
    !locked |-> !byte_vld_o);                                    // R1
  AST_RESYNC_QUIET: assert property (@(negedge clk) disable iff (!rst_n)
    resync_o |-> (!byte_vld_o && !frame_start_o));               // R8
  AST_RESYNC_AFTER_LOCK: assert property (@(negedge clk) disable iff (!rst_n)
    resync_o |-> $past(locked));                                 // R8
  AST_SLOT_IN_FRAME: assert property (@(negedge clk) disable iff (!rst_n)
    byte_vld_o |-> (slot_o <= slot_last(mode_q)));               // R3
  AST_FRAME_FLAG_APART: assert property (@(negedge clk) disable iff (!rst_n)
    frame_start_o |-> !byte_vld_o);                              // R6
endmodule

bind tdm_hwy_deser tdm_hwy_deser_chk i_chk (
  .clk           (sclk),
  .rst_n         (rst_n),
  .byte_vld_o    (byte_vld_o),
  .frame_start_o (frame_start_o),
  .resync_o      (resync_o),
  .slot_o        (slot_o),
  .locked        (locked_w),
  .mode_q        (mode_w)
);

// File: tb/test_tdm_hwy_deser.sv
module test_tdm_hwy_deser;
  logic       sclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync_i = 1'b0;
  logic       sdata_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [5:0] ts_ofs_i = '0;
  logic [2:0] clk_ofs_i = '0;
  logic       edge_adj_i = 1'b0;
  logic [7:0] byte_o;
  logic [5:0] slot_o;
  logic       byte_vld_o, frame_start_o, resync_o;

  int n_vec = 0;
  int n_bad = 0;
  int salt;

  tdm_hwy_deser i_tdm_hwy_deser (.*);

  always #10 sclk = ~sclk;

  function automatic int b_cpb(int m);
    return (m == 0) ? 1 : (m == 1) ? 2 : 4;
  endfunction
  function automatic int b_ns(int m);
    return (m == 1) ? 64 : 32;
  endfunction
  function automatic logic [7:0] b_val(int fr, int sl);
    return 8'((fr * 73 + sl * 29 + salt) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fsync_i = 1'b0;
    repeat (3) @(posedge sclk);
    rst_n = 1'b1;
    @(posedge sclk);
    chk(byte_vld_o == 0 && frame_start_o == 0 && resync_o == 0 && byte_o == 0 && slot_o == 0,
        "R1 reset", {byte_vld_o, frame_start_o, resync_o}, 0);
  endtask

  task automatic run_case(input int mode, input int tso, input int cso, input int adj,
                          input int s1, input int s2, input int nedges);
    int cpb, ns, frm, dd, r, t, slot, bitn;
    bit e_vld, e_fs, e_rs, was_exp, sync;
    logic [7:0] e_byte;
    int e_slot;
    string rs_tag, vld_tag;
    cpb = b_cpb(mode); ns = b_ns(mode);
    frm = ns * 8 * cpb;
    dd  = tso * 8 * cpb + cso + adj;
    salt = int'($urandom % 256);
    do_reset();
    r = -1; e_vld = 0; e_fs = 0; e_rs = 0; e_byte = 0; e_slot = 0;
    rs_tag = "R8"; vld_tag = "R1";
    for (int k = 0; k <= nedges + 1; k++) begin
      @(posedge sclk);
      if (k > 0) begin
        chk(byte_vld_o == e_vld, vld_tag, byte_vld_o, e_vld);
        if (e_vld) begin
          chk(byte_o == e_byte, "R2 R5 R9 byte", byte_o, e_byte);
          chk(slot_o == 6'(e_slot), "R3 R6 slot", slot_o, e_slot);
        end
        chk(frame_start_o == e_fs, "R6 frame start", frame_start_o, e_fs);
        chk(resync_o == e_rs, rs_tag, resync_o, e_rs);
      end
      sync = (k == s1) || (s2 > 0 && k == s2);
      e_rs = 0;
      rs_tag = "R8";
      if (sync) begin
        was_exp = (r >= 0) && ((k - r) % frm == 0);
        if (was_exp) rs_tag = "R7";
        else begin
          e_rs = (r >= 0);
          r = k;
        end
      end
      fsync_i = sync;
      if (sync) begin
        mode_i = 2'(mode); ts_ofs_i = 6'(tso); clk_ofs_i = 3'(cso); edge_adj_i = 1'(adj);
      end else begin
        mode_i = 2'($urandom); ts_ofs_i = 6'($urandom); clk_ofs_i = 3'($urandom);
        edge_adj_i = 1'($urandom);
      end
      t = (r >= 0) ? (k - r - 1 - dd) : -1;
      vld_tag = (r < 0) ? "R1" : (t < 0) ? "R4" : "R5";
      sdata_i = 1'($urandom);
      e_vld = 0; e_fs = 0;
      if (t >= 0) begin
        slot = (t / (8 * cpb)) % ns;
        bitn = (t / cpb) % 8;
        e_byte = b_val(t / frm, slot);
        if (t % cpb == cpb - 1) sdata_i = e_byte[7 - bitn];
        e_vld = (t % (8 * cpb) == 8 * cpb - 1);
        e_slot = slot;
        e_fs = (t % frm == 0);
      end
    end
    fsync_i = 1'b0;
  endtask

  initial begin
    repeat (300000) @(posedge sclk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int m, tso, cso, adj, s1, s2, frm, dd;
    void'($urandom(32'd5150));
    // R1 R4 R6: 1 clock per bit, zero offset, two frames free running
    run_case(0, 0, 0, 0, 5, 0, 5 + 600);
    // R7 R9: on-grid sync two frames later, 2 clocks per bit
    run_case(1, 3, 5, 1, 10, 10 + 2 * 1024, 2700);
    // R8 R4: maximum offset, off-grid resync mid stream
    run_case(2, 63, 7, 1, 3, 3 + 2024 + 500, 3 + 2024 + 500 + 2024 + 1200);
    // R3: code 3 behaves as 4 clocks per bit
    run_case(3, 1, 2, 0, 4, 0, 1500);
    // R8: off-grid sync while still counting the offset
    run_case(0, 31, 7, 1, 2, 100, 100 + 256 + 300);
    for (int i = 0; i < 4; i++) begin
      m = int'($urandom % 4); tso = int'($urandom % 64);
      cso = int'($urandom % 8); adj = int'($urandom % 2);
      frm = b_ns(m) * 8 * b_cpb(m);
      dd = tso * 8 * b_cpb(m) + cso + adj;
      s1 = int'($urandom % 20) + 1;
      if (i % 2 == 0) s2 = s1 + frm * (1 + int'($urandom % 2));
      else            s2 = s1 + 1 + int'($urandom % 3000);
      run_case(m, tso, cso, adj, s1, s2, s2 + dd + frm + 300);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule